// File: doc/BRIEF.md
# PHY Power-State Speed Manager

This block is the control state machine that connects a MAC's device power state to a copper PHY. On every change of the requested power state it makes one decision. The PHY can power down completely. It can restart auto-negotiation with a new set of advertised speeds. Or it can keep its current link. The decision depends on whether a link must stay up in the low-power state (wakeup or manageability enabled) and on whether speed management is enabled.

Powering down fully stops energy detection and stops all activity on the wire. Returning to full power restarts auto-negotiation with every speed advertised. If that attempt fails, the PHY waits in an energy-detect state. With speed management enabled, a 1000 Mbps link that must stay up in low power is renegotiated to 10/100 only. It is renegotiated at all speeds once full power returns.

Top module: `phy_pm_speed_mgr`

## Requirements
- R1: `rst_n` is a synchronous active-low reset. During reset `phy_pdown`=0, `ed_en`=0, `an_restart`=0 and `adv_mask`=3'b111. In the first cycle after release, `an_restart` is high for exactly one cycle and `adv_mask`=3'b111.
- R2: The power state is encoded on `pwr_state` as 2'b00=full power, 2'b01=full power unpowered, 2'b11=deep sleep, and 2'b10 is treated as deep sleep. Suppose the state changes to a non-full-power code while `wake_en`=0 and `mng_en`=0. Then one cycle later `phy_pdown`=1, `ed_en`=0, and no restart strobe is issued.
- R3: While `phy_pdown` stays high and `pwr_state` does not change, `ed_en` stays 0 and `an_restart` stays 0. No link pulses are requested.
- R4: A change to full power from power-down gives, one cycle later, `phy_pdown`=0, a one-cycle `an_restart`, and `adv_mask`=3'b111.
- R5: After such a restart, `an_fail` received while `an_done` is low sets `ed_en`=1 one cycle later. A later `link_up`=1 clears `ed_en` one cycle after that.
- R6: Suppose the state changes to a non-full-power code with a link required, while `pm_en`=1, `link_up`=1 and `link_speed`=2'b10 (1000 Mbps). Then one cycle later `an_restart` pulses and `adv_mask`=3'b011.
- R7: A change back to full power from that reduced-advertisement state pulses `an_restart` one cycle later with `adv_mask`=3'b111.
- R8: With a link required and `pm_en`=0, entering a low-power code issues no strobe, leaves `adv_mask` unchanged and keeps `phy_pdown`=0.
- R9: With a link required and `pm_en`=1, entering a low-power code while `link_speed` is 2'b00 (10) or 2'b01 (100) issues no strobe.
- R10: Decisions are made only when the `pwr_state` code differs from the previous cycle's code. Changes to the other inputs alone cause no strobe. `an_restart` never lasts more than one cycle. `adv_mask` changes only in the cycle of a strobe.
- R11: In `adv_mask`, bit 0 stands for 10 Mbps, bit 1 for 100 Mbps and bit 2 for 1000 Mbps, all full duplex. Half duplex is never advertised, and only bit 2 is ever cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_state | input | 2 | Requested device power state |
| wake_en | input | 1 | Wakeup enabled (link required) |
| mng_en | input | 1 | Manageability enabled (link required) |
| pm_en | input | 1 | Speed-management enable |
| link_up | input | 1 | PHY link status |
| link_speed | input | 2 | Current link speed: 00=10, 01=100, 10=1000 |
| an_done | input | 1 | Auto-negotiation completed |
| an_fail | input | 1 | Auto-negotiation failed |
| phy_pdown | output | 1 | PHY power-down control |
| ed_en | output | 1 | Energy-detect enable |
| an_restart | output | 1 | One-cycle auto-negotiation restart strobe |
| adv_mask | output | 3 | Advertised full-duplex speeds |

## Verification
Each result is registered once. A change on `pwr_state`, `an_fail` or `link_up` that is present at a rising edge shows up on `phy_pdown`, `ed_en`, `an_restart` and `adv_mask` just after that edge. The reset-release strobe appears after the first edge with `rst_n` high. The bench drives inputs on falling edges and samples outputs on the next falling edge, which falls in exactly the cycle in which a strobe is visible. For the cases where no restart is expected, it counts strobes over several following cycles.

// File: rtl/phy_pm_pkg.sv
// Shared encodings for the PHY power-state speed manager.
// Assumes a 2-bit power-state code and a 2-bit link-speed code.
package phy_pm_pkg;
    localparam int PS_W  = 2;
    localparam int SPD_W = 2;
    localparam int ADV_W = 3;

    localparam logic [PS_W-1:0]  PS_FULL  = 2'b00;
    localparam logic [PS_W-1:0]  PS_UNPWR = 2'b01;
    localparam logic [PS_W-1:0]  PS_SLEEP = 2'b11;

    localparam logic [SPD_W-1:0] SPD_10   = 2'b00;
    localparam logic [SPD_W-1:0] SPD_100  = 2'b01;
    localparam logic [SPD_W-1:0] SPD_1000 = 2'b10;

    localparam logic [ADV_W-1:0] ADV_ALL  = 3'b111;
    localparam logic [ADV_W-1:0] ADV_SLOW = 3'b011;

    typedef enum logic [2:0] {
        ST_NEGOT  = 3'd0,   // waiting for auto-negotiation after power-up
        ST_RUN    = 3'd1,   // full power, link established
        ST_OFF    = 3'd2,   // PHY powered down
        ST_LISTEN = 3'd3,   // energy detect after failed negotiation
        ST_SLOW   = 3'd4,   // low power, reduced advertisement
        ST_KEEP   = 3'd5    // low power, link kept as is
    } mgr_state_t;
endpackage

// File: rtl/pm_state_track.sv
// Remembers the last accepted power-state code and flags a change.
// Assumes the caller freezes it (hold) during the post-reset restart cycle
// so that a request present at reset release is evaluated afterwards.
module pm_state_track
    import phy_pm_pkg::*;
#(
    parameter int W = PS_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hold,
    input  logic [W-1:0] pwr_state,
    output logic         chg,
    output logic         tgt_low
);
    logic [W-1:0] prev_q;

    // Capture the accepted code; reset assumes full power.
    always_ff @(posedge clk) begin
        if (!rst_n)     prev_q <= W'(PS_FULL);
        else if (!hold) prev_q <= pwr_state;
    end

    // Change flag and target classification.
    always_comb begin
        chg     = (pwr_state != prev_q);
        tgt_low = (pwr_state != W'(PS_FULL));
    end

    // R10: an accepted code is the one present at the previous edge.
    p_track_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !hold |=> (prev_q == $past(pwr_state)));
endmodule

// File: rtl/pm_decide.sv
// Main decision state machine: selects power-down, energy detect and
// requests auto-negotiation restarts with a requested speed mask.
// Assumes chg/tgt_low come from pm_state_track on the same clock.
module pm_decide
    import phy_pm_pkg::*;
#(
    parameter int SW = SPD_W,
    parameter int AW = ADV_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          chg,
    input  logic          tgt_low,
    input  logic          link_req,
    input  logic          pm_en,
    input  logic          link_up,
    input  logic [SW-1:0] link_speed,
    input  logic          an_done,
    input  logic          an_fail,
    output logic          boot,
    output logic          rs_req,
    output logic [AW-1:0] rs_mask,
    output logic          phy_pdown,
    output logic          ed_en
);
    mgr_state_t st_q, st_d;
    logic       boot_q;
    logic       fast;

    assign boot = boot_q;
    assign fast = link_up && (link_speed == SW'(SPD_1000));

    // One restart request right after reset release.
    always_ff @(posedge clk) begin
        if (!rst_n) boot_q <= 1'b1;
        else        boot_q <= 1'b0;
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_NEGOT;
        else        st_q <= st_d;
    end

    // Next state and restart request.
    always_comb begin
        st_d    = st_q;
        rs_req  = 1'b0;
        rs_mask = AW'(ADV_ALL);
        if (boot_q) begin
            st_d   = ST_NEGOT;
            rs_req = 1'b1;
        end else if (chg && !tgt_low) begin
            case (st_q)
                ST_OFF, ST_SLOW: begin
                    st_d   = ST_NEGOT;
                    rs_req = 1'b1;
                end
                ST_KEEP: st_d = ST_RUN;
                default: st_d = st_q;
            endcase
        end else if (chg) begin
            if (!link_req) begin
                st_d = ST_OFF;
            end else if (st_q == ST_OFF) begin
                rs_req  = 1'b1;
                rs_mask = pm_en ? AW'(ADV_SLOW) : AW'(ADV_ALL);
                st_d    = pm_en ? ST_SLOW : ST_KEEP;
            end else if (st_q == ST_SLOW) begin
                st_d = ST_SLOW;
            end else if (pm_en && fast) begin
                rs_req  = 1'b1;
                rs_mask = AW'(ADV_SLOW);
                st_d    = ST_SLOW;
            end else begin
                st_d = ST_KEEP;
            end
        end else begin
            case (st_q)
                ST_NEGOT: begin
                    if (an_done && link_up) st_d = ST_RUN;
                    else if (an_fail)       st_d = ST_LISTEN;
                end
                ST_LISTEN: if (link_up) st_d = ST_RUN;
                default: st_d = st_q;
            endcase
        end
    end

    // Output decode from the registered state.
    always_comb begin
        phy_pdown = (st_q == ST_OFF);
        ed_en     = (st_q == ST_LISTEN);
    end

    // R2: low power with no link required powers the PHY down.
    p_off_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!boot_q && chg && tgt_low && !link_req) |=> phy_pdown);
    // R5: a failed negotiation enables energy detect.
    p_listen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!boot_q && !chg && st_q == ST_NEGOT && !an_done && an_fail) |=> ed_en);
endmodule

// File: rtl/pm_an_ctrl.sv
// Turns restart requests into a one-cycle strobe and holds the advertised
// speed mask between requests. Assumes requests are single-cycle.
module pm_an_ctrl
    import phy_pm_pkg::*;
#(
    parameter int AW = ADV_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rs_req,
    input  logic [AW-1:0] rs_mask,
    output logic          an_restart,
    output logic [AW-1:0] adv_mask
);
    // Strobe register.
    always_ff @(posedge clk) begin
        if (!rst_n) an_restart <= 1'b0;
        else        an_restart <= rs_req;
    end

    // Mask register, loaded only with a request.
    always_ff @(posedge clk) begin
        if (!rst_n)      adv_mask <= AW'(ADV_ALL);
        else if (rs_req) adv_mask <= rs_mask;
    end

    // R10: the strobe lasts one cycle.
    p_strobe_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        an_restart |=> !an_restart);
    // R10: the mask moves only together with a strobe.
    p_mask_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !an_restart |-> $stable(adv_mask));
    // R11: the 10 and 100 bits are always advertised.
    p_low_bits_r11: assert property (@(posedge clk) disable iff (!rst_n)
        adv_mask[1:0] == 2'b11);
endmodule

// File: rtl/phy_pm_speed_mgr.sv
// Top of the PHY power-state speed manager. Connects change tracking,
// the decision FSM and the restart/mask output stage.
// Assumes all inputs are synchronous to clk.
module phy_pm_speed_mgr
    import phy_pm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PS_W-1:0]  pwr_state,
    input  logic             wake_en,
    input  logic             mng_en,
    input  logic             pm_en,
    input  logic             link_up,
    input  logic [SPD_W-1:0] link_speed,
    input  logic             an_done,
    input  logic             an_fail,
    output logic             phy_pdown,
    output logic             ed_en,
    output logic             an_restart,
    output logic [ADV_W-1:0] adv_mask
);
    logic             chg, tgt_low, boot, rs_req, link_req;
    logic [ADV_W-1:0] rs_mask;

    assign link_req = wake_en || mng_en;

    pm_state_track #(.W(PS_W)) i_track (
        .clk(clk), .rst_n(rst_n), .hold(boot), .pwr_state(pwr_state),
        .chg(chg), .tgt_low(tgt_low)
    );

    pm_decide #(.SW(SPD_W), .AW(ADV_W)) i_decide (
        .clk(clk), .rst_n(rst_n), .chg(chg), .tgt_low(tgt_low),
        .link_req(link_req), .pm_en(pm_en), .link_up(link_up),
        .link_speed(link_speed), .an_done(an_done), .an_fail(an_fail),
        .boot(boot), .rs_req(rs_req), .rs_mask(rs_mask),
        .phy_pdown(phy_pdown), .ed_en(ed_en)
    );

    pm_an_ctrl #(.AW(ADV_W)) i_an (
        .clk(clk), .rst_n(rst_n), .rs_req(rs_req), .rs_mask(rs_mask),
        .an_restart(an_restart), .adv_mask(adv_mask)
    );

    // R3: a PHY that stays powered down gets no restart.
    p_off_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (phy_pdown && !chg) |=> !an_restart);
    // R6: a 1000 Mbps link needed in low power is renegotiated to 10/100.
    p_slow_down_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!boot && chg && tgt_low && link_req && pm_en && link_up &&
         link_speed == SPD_1000 && adv_mask[2] && !phy_pdown)
        |=> (an_restart && adv_mask == ADV_SLOW));
    // R8: with speed management off, the link is kept without restart.
    p_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!boot && chg && tgt_low && link_req && !pm_en && !phy_pdown)
        |=> (!an_restart && !phy_pdown));
    // R4: leaving power-down for full power restarts with every speed.
    p_wake_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (phy_pdown && chg && !tgt_low) |=> (an_restart && adv_mask == ADV_ALL && !phy_pdown));
endmodule

// File: tb/test_phy_pm_speed_mgr.sv
module test_phy_pm_speed_mgr;
    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] pwr_state = 2'b00;
    logic       wake_en = 1'b0, mng_en = 1'b0, pm_en = 1'b0;
    logic       link_up = 1'b0, an_done = 1'b0, an_fail = 1'b0;
    logic [1:0] link_speed = 2'b00;
    logic       phy_pdown, ed_en, an_restart;
    logic [2:0] adv_mask;

    int  total = 0;
    int  bad = 0;
    bit  done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    phy_pm_speed_mgr i_phy_pm_speed_mgr (
        .clk(clk), .rst_n(rst_n), .pwr_state(pwr_state), .wake_en(wake_en),
        .mng_en(mng_en), .pm_en(pm_en), .link_up(link_up),
        .link_speed(link_speed), .an_done(an_done), .an_fail(an_fail),
        .phy_pdown(phy_pdown), .ed_en(ed_en), .an_restart(an_restart),
        .adv_mask(adv_mask)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    // Runs n cycles and returns how many restart strobes were seen.
    task automatic count_strobes(input int n, output int cnt);
        cnt = 0;
        for (int i = 0; i < n; i++) begin
            step();
            if (an_restart) cnt++;
        end
    endtask

    // Brings the link up at the given speed with full power requested.
    task automatic settle_link(input logic [1:0] spd);
        link_up = 1'b1; link_speed = spd; an_done = 1'b1;
        step(); step();
        an_done = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        step(); step();
        check("R1 pdown in reset", phy_pdown, 0);
        check("R1 ed in reset", ed_en, 0);
        check("R1 strobe in reset", an_restart, 0);
        check("R1 mask in reset", adv_mask, 7);
        rst_n = 1'b1;
        step();
        check("R1 strobe after release", an_restart, 1);
        check("R1 mask after release", adv_mask, 7);
        step();
        check("R1 strobe one cycle", an_restart, 0);
    endtask

    task automatic t_powerdown();
        int cnt;
        wake_en = 1'b0; mng_en = 1'b0; pwr_state = 2'b11;
        step();
        check("R2 pdown", phy_pdown, 1);
        check("R2 ed off", ed_en, 0);
        check("R2 no strobe", an_restart, 0);
        link_up = 1'b0; pm_en = 1'b1;
        count_strobes(6, cnt);
        check("R3 no strobe while off", cnt, 0);
        check("R3 ed stays off", ed_en, 0);
        check("R3 still down", phy_pdown, 1);
        pwr_state = 2'b00;
        step();
        check("R4 pdown released", phy_pdown, 0);
        check("R4 strobe", an_restart, 1);
        check("R4 mask all", adv_mask, 7);
        an_fail = 1'b1;
        step();
        an_fail = 1'b0;
        check("R5 energy detect on", ed_en, 1);
        link_up = 1'b1; link_speed = 2'b10;
        step();
        check("R5 energy detect off", ed_en, 0);
    endtask

    task automatic t_unpowered_pdown();
        wake_en = 1'b0; mng_en = 1'b0; pwr_state = 2'b01;
        step();
        check("R2 pdown from unpowered code", phy_pdown, 1);
        pwr_state = 2'b00;
        step();
        check("R4 strobe from unpowered", an_restart, 1);
        settle_link(2'b10);
    endtask

    task automatic t_reduce();
        int cnt;
        wake_en = 1'b1; pm_en = 1'b1; pwr_state = 2'b11;
        step();
        check("R6 strobe", an_restart, 1);
        check("R6 mask 10/100", adv_mask, 3);
        check("R11 only 1000 bit cleared", adv_mask[1:0], 3);
        link_speed = 2'b01;
        count_strobes(4, cnt);
        check("R10 mask held", adv_mask, 3);
        check("R10 no extra strobe", cnt, 0);
        pwr_state = 2'b01;
        count_strobes(3, cnt);
        check("R10 low-to-low no strobe", cnt, 0);
        pwr_state = 2'b00;
        step();
        check("R7 strobe", an_restart, 1);
        check("R7 mask all", adv_mask, 7);
        wake_en = 1'b0;
        settle_link(2'b10);
    endtask

    task automatic t_keep();
        int cnt;
        pm_en = 1'b0; mng_en = 1'b1; pwr_state = 2'b11;
        step();
        check("R8 no strobe", an_restart, 0);
        check("R8 no pdown", phy_pdown, 0);
        count_strobes(3, cnt);
        check("R8 quiet", cnt, 0);
        check("R8 mask unchanged", adv_mask, 7);
        pwr_state = 2'b00;
        count_strobes(3, cnt);
        check("R8 return without strobe", cnt, 0);
        mng_en = 1'b0;
    endtask

    task automatic t_slow_link();
        int cnt;
        link_speed = 2'b01; pm_en = 1'b1; wake_en = 1'b1; pwr_state = 2'b11;
        count_strobes(3, cnt);
        check("R9 no strobe at 100", cnt, 0);
        check("R9 mask all", adv_mask, 7);
        pwr_state = 2'b00;
        count_strobes(2, cnt);
        wake_en = 1'b0; link_speed = 2'b10;
    endtask

    task automatic t_steady();
        int cnt;
        pm_en = 1'b1; wake_en = 1'b1; link_speed = 2'b10;
        step();
        wake_en = 1'b0; mng_en = 1'b1;
        step();
        link_speed = 2'b01; mng_en = 1'b0;
        count_strobes(4, cnt);
        check("R10 no strobe without state change", cnt, 0);
        check("R10 mask unchanged", adv_mask, 7);
    endtask

    initial begin
        t_reset();
        settle_link(2'b10);
        t_powerdown();
        settle_link(2'b10);
        t_unpowered_pdown();
        t_reduce();
        t_keep();
        t_slow_link();
        t_steady();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule